// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits beside the system-control registers of a single-issue pipeline whose branches carry a delay slot. When the pipeline raises a one-cycle exception request, the request names the kind of exception, the faulting virtual address, the address-space identifier in use and, where it applies, a coprocessor number. On the next clock edge the block updates, all together, the exception-level bit, the cause fields, the saved exception PC, the bad-address register, the shadow register set selectors, the translation entry-high fields and the context page field. In the same cycle it presents a redirect: the handler address and the two sequential addresses after it, with a pipeline flush strobe.

The handler address depends on the exception kind and on configuration the block reads but does not own: the exception base, the boot-vector select bit (BEV), the dedicated-interrupt-vector bit (IV) and the exception shadow set. All of these are sampled together with the block's own exception-level bit, using their values from before the update. Reset also goes through the redirect port. It presents the boot address and marks coprocessor 1 as usable.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the redirect shows 0xBFC00000, 0xBFC00004 and 0xBFC00008 with valid and flush high, cop1 usable reads 1, the exception level reads 0, and every saved register reads 0. A request presented during reset changes nothing.
- R2: Every accepted request sets the exception level to 1, whether or not it was already set.
- R3: The cause code is 1 for TLB modified, 2 for TLB refill or invalid on load/fetch, 3 for TLB refill or invalid on store, 4 for address error on load, 5 for address error on store, 8 for syscall, 9 for breakpoint, 0xA for reserved instruction, 0xB for coprocessor unusable, 0xC for overflow, 0xD for trap and 0 for interrupt. Request kind encodings are 0 interrupt, 1 TLB modified, 2 load refill, 3 load invalid, 4 store refill, 5 store invalid, 6 load address error, 7 store address error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow and 13 trap.
- R4: When the next PC differs from PC+4, the saved PC is PC-4 and the delay-slot flag is 1. Otherwise the saved PC is PC and the flag is 0.
- R5: The coprocessor-error field takes the request's coprocessor number for a coprocessor-unusable exception and 0 for any other kind.
- R6: The handler address is base+0x180 for all kinds except those in R7 and R8, and except an overflow taken while BEV is 1, whose handler is 0xBFC00200.
- R7: A TLB refill (load or store) goes to base+0x000 when the exception level was 0 before the request, and to base+0x180 when it was already 1.
- R8: An interrupt goes to base+0x200 when IV is 1 and to base+0x180 when IV is 0.
- R9: Only when the exception level and BEV were both 0 does the previous-set field take the current set and the current set take the exception set. Otherwise both fields stay unchanged.
- R10: The bad address takes the faulting address for the address-error and all TLB kinds, and it keeps its value for every other kind.
- R11: For TLB kinds only, the entry-high page field and the context page field take address bits 31:13 and the entry-high ASID takes the request ASID. For other kinds they keep their values.
- R12: In the cycle after a request, the redirect shows the handler address, handler+4 and handler+8 with valid and flush high. In the cycle after a cycle with no request, valid and flush are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle exception request |
| req_kind | input | 4 | Exception kind (encoding in R3) |
| req_pc | input | 32 | PC of faulting instruction |
| req_npc | input | 32 | Next PC at the time of the fault |
| req_vaddr | input | 32 | Faulting virtual address |
| req_asid | input | 8 | Address-space identifier in use |
| req_cop_id | input | 2 | Coprocessor number for unusable faults |
| cfg_ebase | input | 32 | Exception vector base |
| cfg_bev | input | 1 | Boot-vector select |
| cfg_iv | input | 1 | Dedicated interrupt vector enable |
| cfg_ess | input | 4 | Shadow set to use on exception |
| redir_valid | output | 1 | Redirect present |
| redir_flush | output | 1 | Pipeline flush strobe |
| redir_pc | output | 32 | New current PC |
| redir_npc | output | 32 | New next PC |
| redir_nnpc | output | 32 | New next-next PC |
| st_exl | output | 1 | Exception level |
| st_cu1 | output | 1 | Coprocessor 1 usable |
| cs_code | output | 5 | Cause exception code |
| cs_bd | output | 1 | Delay-slot flag |
| cs_ce | output | 2 | Coprocessor error field |
| epc | output | 32 | Saved exception PC |
| bad_va | output | 32 | Faulting address |
| sh_prev | output | 4 | Previous shadow set |
| sh_cur | output | 4 | Current shadow set |
| eh_vpn2 | output | 19 | Entry-high page field |
| eh_asid | output | 8 | Entry-high ASID |
| ctx_vpn2 | output | 19 | Context page field |

## Verification
A stale exception level shows up only at the next request: a second refill goes to the wrong vector, or the shadow sets swap again, one cycle after that request. The tests therefore chain requests without resetting between them. A wrong delay-slot decision or code mapping appears on the saved PC and cause fields one cycle after the request. Holding registers that are written by mistake show up only when a later kind that should leave them alone is taken, so every such kind is followed by a check of the untouched values.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

  typedef enum logic [3:0] {
    XK_INTR        = 4'd0,
    XK_TLB_MOD     = 4'd1,
    XK_TLBL_REFILL = 4'd2,
    XK_TLBL_INVAL  = 4'd3,
    XK_TLBS_REFILL = 4'd4,
    XK_TLBS_INVAL  = 4'd5,
    XK_ADDR_LD     = 4'd6,
    XK_ADDR_ST     = 4'd7,
    XK_SYSCALL     = 4'd8,
    XK_BREAK       = 4'd9,
    XK_RESV        = 4'd10,
    XK_COP_UNUSE   = 4'd11,
    XK_OVF         = 4'd12,
    XK_TRAP        = 4'd13
  } xkind_e;

  localparam int CODE_W = 5;

  function automatic logic [CODE_W-1:0] code_of(input xkind_e k);
    case (k)
      XK_TLB_MOD:                    code_of = 5'h01;
      XK_TLBL_REFILL, XK_TLBL_INVAL: code_of = 5'h02;
      XK_TLBS_REFILL, XK_TLBS_INVAL: code_of = 5'h03;
      XK_ADDR_LD:                    code_of = 5'h04;
      XK_ADDR_ST:                    code_of = 5'h05;
      XK_SYSCALL:                    code_of = 5'h08;
      XK_BREAK:                      code_of = 5'h09;
      XK_RESV:                       code_of = 5'h0A;
      XK_COP_UNUSE:                  code_of = 5'h0B;
      XK_OVF:                        code_of = 5'h0C;
      XK_TRAP:                       code_of = 5'h0D;
      default:                       code_of = 5'h00;
    endcase
  endfunction

  function automatic logic is_tlb(input xkind_e k);
    is_tlb = (k == XK_TLB_MOD) || (k == XK_TLBL_REFILL) || (k == XK_TLBL_INVAL) ||
             (k == XK_TLBS_REFILL) || (k == XK_TLBS_INVAL);
  endfunction

  function automatic logic is_refill(input xkind_e k);
    is_refill = (k == XK_TLBL_REFILL) || (k == XK_TLBS_REFILL);
  endfunction

  function automatic logic takes_badva(input xkind_e k);
    takes_badva = is_tlb(k) || (k == XK_ADDR_LD) || (k == XK_ADDR_ST);
  endfunction

endpackage

// File: rtl/exc_vector_sel.sv
`timescale 1ns/1ps
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] OFS_GEN   = 32'h180,
  parameter logic [31:0] OFS_INTR  = 32'h200,
  parameter logic [31:0] BOOT_OVF  = 32'hBFC00200
) (
  input  xkind_e            kind,
  input  logic [XLEN-1:0]   ebase,
  input  logic              exl_prev,
  input  logic              bev,
  input  logic              iv,
  output logic [XLEN-1:0]   handler
);
  localparam logic [XLEN-1:0] GEN_OFS  = XLEN'(OFS_GEN);
  localparam logic [XLEN-1:0] INT_OFS  = XLEN'(OFS_INTR);
  localparam logic [XLEN-1:0] OVF_BOOT = XLEN'(BOOT_OVF);

  always_comb begin
    handler = ebase + GEN_OFS;
    if (is_refill(kind)) begin
      handler = exl_prev ? (ebase + GEN_OFS) : ebase;
    end else if (kind == XK_INTR) begin
      handler = iv ? (ebase + INT_OFS) : (ebase + GEN_OFS);
    end else if (kind == XK_OVF && bev) begin
      handler = OVF_BOOT;
    end
  end
endmodule

// File: rtl/exc_epc_calc.sv
`timescale 1ns/1ps
module exc_epc_calc #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] npc,
  output logic [XLEN-1:0] epc_next,
  output logic            in_slot
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    in_slot  = (npc != pc + STEP);
    epc_next = in_slot ? (pc - STEP) : pc;
  end
endmodule

// File: rtl/exc_shadow_upd.sv
`timescale 1ns/1ps
module exc_shadow_upd #(
  parameter int SET_W = 4
) (
  input  logic             exl_prev,
  input  logic             bev,
  input  logic [SET_W-1:0] ess,
  input  logic [SET_W-1:0] cur,
  input  logic [SET_W-1:0] prev,
  output logic [SET_W-1:0] cur_next,
  output logic [SET_W-1:0] prev_next
);
  logic swap;
  always_comb begin
    swap      = !exl_prev && !bev;
    cur_next  = swap ? ess : cur;
    prev_next = swap ? cur : prev;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          ASID_W     = 8,
  parameter int          SET_W      = 4,
  parameter int          COP_W      = 2,
  parameter int          PAGE_SHIFT = 13,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] RESET_VEC  = 32'hBFC00000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [3:0]                 req_kind,
  input  logic [XLEN-1:0]            req_pc,
  input  logic [XLEN-1:0]            req_npc,
  input  logic [XLEN-1:0]            req_vaddr,
  input  logic [ASID_W-1:0]          req_asid,
  input  logic [COP_W-1:0]           req_cop_id,
  input  logic [XLEN-1:0]            cfg_ebase,
  input  logic                       cfg_bev,
  input  logic                       cfg_iv,
  input  logic [SET_W-1:0]           cfg_ess,
  output logic                       redir_valid,
  output logic                       redir_flush,
  output logic [XLEN-1:0]            redir_pc,
  output logic [XLEN-1:0]            redir_npc,
  output logic [XLEN-1:0]            redir_nnpc,
  output logic                       st_exl,
  output logic                       st_cu1,
  output logic [CODE_W-1:0]          cs_code,
  output logic                       cs_bd,
  output logic [COP_W-1:0]           cs_ce,
  output logic [XLEN-1:0]            epc,
  output logic [XLEN-1:0]            bad_va,
  output logic [SET_W-1:0]           sh_prev,
  output logic [SET_W-1:0]           sh_cur,
  output logic [XLEN-PAGE_SHIFT-1:0] eh_vpn2,
  output logic [ASID_W-1:0]          eh_asid,
  output logic [XLEN-PAGE_SHIFT-1:0] ctx_vpn2
);
  localparam int              VPN_W = XLEN - PAGE_SHIFT;
  localparam logic [XLEN-1:0] STEP  = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] RVEC  = XLEN'(RESET_VEC);

  xkind_e kind;
  assign kind = xkind_e'(req_kind);

  logic [XLEN-1:0]  handler, epc_nx;
  logic             slot;
  logic [SET_W-1:0] cur_nx, prev_nx;

  exc_vector_sel #(.XLEN(XLEN)) u_vec (
    .kind(kind), .ebase(cfg_ebase), .exl_prev(st_exl),
    .bev(cfg_bev), .iv(cfg_iv), .handler(handler)
  );

  exc_epc_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
    .pc(req_pc), .npc(req_npc), .epc_next(epc_nx), .in_slot(slot)
  );

  exc_shadow_upd #(.SET_W(SET_W)) u_sh (
    .exl_prev(st_exl), .bev(cfg_bev), .ess(cfg_ess),
    .cur(sh_cur), .prev(sh_prev), .cur_next(cur_nx), .prev_next(prev_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b1;
      redir_flush <= 1'b1;
      redir_pc    <= RVEC;
      redir_npc   <= RVEC + STEP;
      redir_nnpc  <= RVEC + 2 * STEP;
      st_exl      <= 1'b0;
      st_cu1      <= 1'b1;
      cs_code     <= '0;
      cs_bd       <= 1'b0;
      cs_ce       <= '0;
      epc         <= '0;
      bad_va      <= '0;
      sh_prev     <= '0;
      sh_cur      <= '0;
      eh_vpn2     <= '0;
      eh_asid     <= '0;
      ctx_vpn2    <= '0;
    end else begin
      redir_valid <= req_valid;
      redir_flush <= req_valid;
      if (req_valid) begin
        redir_pc   <= handler;
        redir_npc  <= handler + STEP;
        redir_nnpc <= handler + 2 * STEP;
        st_exl     <= 1'b1;
        cs_code    <= code_of(kind);
        cs_bd      <= slot;
        cs_ce      <= (kind == XK_COP_UNUSE) ? req_cop_id : '0;
        epc        <= epc_nx;
        sh_cur     <= cur_nx;
        sh_prev    <= prev_nx;
        if (takes_badva(kind)) bad_va <= req_vaddr;
        if (is_tlb(kind)) begin
          eh_vpn2  <= req_vaddr[XLEN-1:PAGE_SHIFT];
          ctx_vpn2 <= req_vaddr[XLEN-1:PAGE_SHIFT];
          eh_asid  <= req_asid;
        end
      end
    end
  end

  p_exl_set_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> st_exl);

  p_redirect_seq_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> redir_valid && redir_flush &&
                  redir_npc == redir_pc + STEP && redir_nnpc == redir_pc + 2 * STEP);

  p_redirect_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !redir_valid && !redir_flush);

  p_slot_epc_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> cs_bd == ($past(req_npc) != $past(req_pc) + STEP) &&
                  epc == (cs_bd ? $past(req_pc) - STEP : $past(req_pc)));

  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && (st_exl || cfg_bev) |=> $stable(sh_cur) && $stable(sh_prev));

  p_badva_hold_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && !takes_badva(kind) |=> $stable(bad_va));

  p_ce_clear_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid && kind != XK_COP_UNUSE |=> cs_ce == '0);

  p_tlb_hold_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid && !is_tlb(kind) |=> $stable(eh_vpn2) && $stable(ctx_vpn2) && $stable(eh_asid));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  logic        clk = 0, rst = 1;
  logic        req_valid = 0;
  logic [3:0]  req_kind = 0;
  logic [31:0] req_pc = 0, req_npc = 0, req_vaddr = 0, cfg_ebase = 32'h80000000;
  logic [7:0]  req_asid = 0;
  logic [1:0]  req_cop_id = 0;
  logic        cfg_bev = 0, cfg_iv = 0;
  logic [3:0]  cfg_ess = 0;
  logic        redir_valid, redir_flush, st_exl, st_cu1, cs_bd;
  logic [31:0] redir_pc, redir_npc, redir_nnpc, epc, bad_va;
  logic [4:0]  cs_code;
  logic [1:0]  cs_ce;
  logic [3:0]  sh_prev, sh_cur;
  logic [18:0] eh_vpn2, ctx_vpn2;
  logic [7:0]  eh_asid;

  int checks = 0, fails = 0;
  localparam logic [31:0] EB = 32'h80000000;

  always #2.5 clk = ~clk;

  exc_entry_ctrl dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fire(input int k, input logic [31:0] pc, input logic [31:0] npc,
                      input logic [31:0] va, input logic [7:0] asid, input logic [1:0] cop);
    @(negedge clk);
    req_valid = 1; req_kind = 4'(k); req_pc = pc; req_npc = npc;
    req_vaddr = va; req_asid = asid; req_cop_id = cop;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic chk_redirect(input string tag, input logic [31:0] h);
    chk(tag, {31'd0, redir_valid}, 1);
    chk(tag, {31'd0, redir_flush}, 1);
    chk(tag, redir_pc, h);
    chk(tag, redir_npc, h + 4);
    chk(tag, redir_nnpc, h + 8);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_valid = 1; req_kind = 4'd6; req_vaddr = 32'hDEAD0000; req_pc = 32'h40;
    req_npc = 32'h44;
    @(negedge clk);
    @(negedge clk);
    rst = 0; req_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_redirect("R1 reset vector", 32'hBFC00000);
    chk("R1 cu1", {31'd0, st_cu1}, 1);
    chk("R1 exl", {31'd0, st_exl}, 0);
    chk("R1 epc", epc, 0);
    chk("R1 badva ignores req in reset", bad_va, 0);
    chk("R1 code", {27'd0, cs_code}, 0);
    @(negedge clk);
    chk("R12 idle valid", {31'd0, redir_valid}, 0);
    chk("R12 idle flush", {31'd0, redir_flush}, 0);
  endtask

  task automatic t_refill_chain();
    do_reset();
    cfg_bev = 0; cfg_ess = 4'd5;
    fire(2, 32'h1000, 32'h1004, 32'h12346000, 8'h3C, 0);
    chk_redirect("R7 refill exl0", EB);
    chk("R3 code ld tlb", {27'd0, cs_code}, 2);
    chk("R2 exl", {31'd0, st_exl}, 1);
    chk("R4 epc", epc, 32'h1000);
    chk("R4 bd", {31'd0, cs_bd}, 0);
    chk("R9 cur", {28'd0, sh_cur}, 5);
    chk("R9 prev", {28'd0, sh_prev}, 0);
    chk("R10 badva", bad_va, 32'h12346000);
    chk("R11 vpn2", {13'd0, eh_vpn2}, 32'h12346000 >> 13);
    chk("R11 ctx", {13'd0, ctx_vpn2}, 32'h12346000 >> 13);
    chk("R11 asid", {24'd0, eh_asid}, 32'h3C);
    cfg_ess = 4'd7;
    fire(4, 32'h2000, 32'h3000, 32'hA0004000, 8'h11, 0);
    chk_redirect("R7 refill exl1", EB + 32'h180);
    chk("R3 code st tlb", {27'd0, cs_code}, 3);
    chk("R4 slot epc", epc, 32'h1FFC);
    chk("R4 slot bd", {31'd0, cs_bd}, 1);
    chk("R2 exl stays", {31'd0, st_exl}, 1);
    chk("R9 no swap exl1 cur", {28'd0, sh_cur}, 5);
    chk("R9 no swap exl1 prev", {28'd0, sh_prev}, 0);
    chk("R11 asid st", {24'd0, eh_asid}, 32'h11);
    @(negedge clk);
    chk("R12 one cycle", {31'd0, redir_valid}, 0);
  endtask

  task automatic t_overflow_bev();
    do_reset();
    cfg_bev = 1; cfg_ess = 4'd9;
    fire(12, 32'h500, 32'h504, 32'h77770000, 8'h22, 0);
    chk_redirect("R6 ovf bev", 32'hBFC00200);
    chk("R3 code ovf", {27'd0, cs_code}, 12);
    chk("R9 no swap bev", {28'd0, sh_cur}, 0);
    chk("R10 badva kept", bad_va, 0);
    chk("R11 vpn2 kept", {13'd0, eh_vpn2}, 0);
    chk("R11 asid kept", {24'd0, eh_asid}, 0);
    cfg_bev = 0;
    fire(12, 32'h500, 32'h504, 32'h0, 8'h0, 0);
    chk_redirect("R6 ovf nobev", EB + 32'h180);
  endtask

  task automatic t_cop_and_mod();
    do_reset();
    cfg_bev = 0; cfg_ess = 4'd3;
    fire(1, 32'h600, 32'h604, 32'h00C02000, 8'h44, 2);
    chk_redirect("R6 tlb mod general", EB + 32'h180);
    chk("R3 code mod", {27'd0, cs_code}, 1);
    chk("R5 ce clear", {30'd0, cs_ce}, 0);
    chk("R9 swap cur", {28'd0, sh_cur}, 3);
    fire(11, 32'h700, 32'h704, 32'h0, 8'h0, 2);
    chk("R5 ce id", {30'd0, cs_ce}, 2);
    chk("R3 code cpu", {27'd0, cs_code}, 11);
    chk("R10 badva kept", bad_va, 32'h00C02000);
    fire(8, 32'h800, 32'h804, 32'h55550000, 8'h99, 3);
    chk("R5 ce cleared", {30'd0, cs_ce}, 0);
    chk("R3 code sys", {27'd0, cs_code}, 8);
    chk("R11 ctx kept", {13'd0, ctx_vpn2}, 32'h00C02000 >> 13);
    chk("R11 asid kept", {24'd0, eh_asid}, 32'h44);
  endtask

  task automatic t_interrupt();
    do_reset();
    cfg_iv = 1;
    fire(0, 32'h900, 32'h904, 32'h0, 8'h0, 0);
    chk_redirect("R8 iv1", EB + 32'h200);
    chk("R3 code intr", {27'd0, cs_code}, 0);
    cfg_iv = 0;
    fire(0, 32'h900, 32'h904, 32'h0, 8'h0, 0);
    chk_redirect("R8 iv0", EB + 32'h180);
  endtask

  task automatic t_codes();
    do_reset();
    fire(3, 32'hA00, 32'hA04, 32'h1000, 8'h1, 0);
    chk("R3 ld inval", {27'd0, cs_code}, 2);
    chk_redirect("R6 inval general", EB + 32'h180);
    fire(5, 32'hA00, 32'hA04, 32'h2000, 8'h2, 0);
    chk("R3 st inval", {27'd0, cs_code}, 3);
    fire(6, 32'hA00, 32'hA04, 32'h3001, 8'h3, 0);
    chk("R3 addr ld", {27'd0, cs_code}, 4);
    chk("R10 addr ld badva", bad_va, 32'h3001);
    chk("R11 addr keeps asid", {24'd0, eh_asid}, 2);
    fire(7, 32'hA00, 32'hA04, 32'h4002, 8'h4, 0);
    chk("R3 addr st", {27'd0, cs_code}, 5);
    chk("R10 addr st badva", bad_va, 32'h4002);
    fire(9, 32'hA00, 32'hA04, 32'h0, 8'h0, 0);
    chk("R3 break", {27'd0, cs_code}, 9);
    fire(10, 32'hA00, 32'hA04, 32'h0, 8'h0, 0);
    chk("R3 resv", {27'd0, cs_code}, 10);
    fire(13, 32'hA00, 32'hA04, 32'h0, 8'h0, 0);
    chk("R3 trap", {27'd0, cs_code}, 13);
    chk("R10 badva kept", bad_va, 32'h4002);
  endtask

  initial begin
    t_reset();
    t_refill_chain();
    t_overflow_bev();
    t_cop_and_mod();
    t_interrupt();
    t_codes();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule